// File: doc/BRIEF.md
# Rate-Selectable Clock-Enable Divider

The block turns a user clock into a divided clock-enable stream, `tick_o`, which is high for one cycle out of every N. A 3-bit rate code picks N from 1, 2, 4 or 8. One code defers to a static default ratio that is fixed by a parameter. The block does not apply a new code at once. When it sees a change of code, it starts a settling timer of `SETTLE_CYCLES` user-clock cycles. When that timer expires, the divider takes the new ratio and `done_o` is raised for a single cycle.

The rate input is normally synchronous to the user clock. When `async_mode_i` is set, the code first passes through a two-flop synchronizer, and change detection works on the synchronized copy. A new change that arrives while the timer is running restarts the timer. Codes outside the defined set are ignored. While reset is asserted the enable stream stops.

Top module: `rate_div`

## Requirements
- R1: Rate code 3'b000 selects the divider 2^DEFAULT_LOG2. It is also the ratio in force after reset, and with the default DEFAULT_LOG2=1 `tick_o` is high one cycle in two.
- R2: Rate codes 3'b001, 3'b010, 3'b011 and 3'b100 give divide-by-1, 2, 4 and 8. With divide-by-N, `tick_o` is high on exactly one cycle of every N.
- R3: Each accepted change of rate code gives exactly one pulse on `done_o`, and that pulse lasts one cycle.
- R4: In synchronous mode, take E as the clock edge that first samples the changed code. `done_o` is high in the cycle after the edge that comes SETTLE_CYCLES edges after E. The new ratio governs `tick_o` from that cycle on.
- R5: With `async_mode_i` high, the code passes through two flops before change detection, so every latency in R4 grows by two cycles.
- R6: While `rst_ni` is low, `tick_o` and `done_o` are low. Leaving reset produces no `done_o` pulse.
- R7: Codes 3'b101, 3'b110 and 3'b111 change neither the ratio nor the timer, and they give no `done_o` pulse.
- R8: A valid change that arrives while the timer runs restarts the timer from SETTLE_CYCLES. Only one `done_o` pulse follows, at the final expiry, and it carries the latest code.
- R9: The divider counter restarts when a new ratio takes effect. The first `tick_o` under ratio N therefore falls N-1 cycles after the `done_o` cycle (the same cycle when N=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | User clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| async_mode_i | input | 1 | 1: rate code is asynchronous and is synchronized first |
| rate_i | input | 3 | Rate code |
| tick_o | output | 1 | Divided clock-enable |
| done_o | output | 1 | One-cycle pulse when a new ratio takes effect |

## Verification
The checker watches several rules on every cycle:
- `done_o` never lasts more than one cycle.
- A pulse on `done_o` only follows a running timer.
- A reserved code never starts the timer.
- Under a ratio above one, a tick is never followed by another tick unless the ratio is switching.
- The enable is low during reset.

Some properties need the bench's scenarios to show them: the exact done latency in each mode, the tick rate for every code, the restart of the timer, and the phase of the first tick after a switch. The bench measures these against cycle counts that it derives from the requirements.

// File: rtl/rate_div_pkg.sv
package rate_div_pkg;
  localparam int MAX_LOG2 = 3;
  localparam int LOG_W    = $clog2(MAX_LOG2 + 1);

  typedef logic [2:0] rate_code_t;

  function automatic logic code_valid(rate_code_t c);
    return c <= 3'd4;
  endfunction

  function automatic logic [LOG_W-1:0] code_log2(rate_code_t c, logic [LOG_W-1:0] dflt);
    case (c)
      3'd1:    return LOG_W'(0);
      3'd2:    return LOG_W'(1);
      3'd3:    return LOG_W'(2);
      3'd4:    return LOG_W'(3);
      default: return dflt;
    endcase
  endfunction
endpackage

// File: rtl/rate_div_sync.sv
module rate_div_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         async_mode_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = async_mode_i ? stg_q[STAGES-1] : d_i;
endmodule

// File: rtl/rate_div_ctrl.sv
module rate_div_ctrl
  import rate_div_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int DEFAULT_LOG2  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  rate_code_t       code_i,
  output logic [LOG_W-1:0] log2_o,
  output logic             fire_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int TMR_W = $clog2(SETTLE_CYCLES + 1);

  if (SETTLE_CYCLES < 1) begin : g_bad_settle
    $error("SETTLE_CYCLES must be at least 1");
  end

  rate_code_t       code_q;
  logic [TMR_W-1:0] tmr_q;
  logic             busy_q, done_q;
  logic [LOG_W-1:0] log2_q;
  logic             change;

  assign change = code_valid(code_i) && (code_i != code_q);
  assign fire_o = busy_q && (tmr_q == TMR_W'(1)) && !change;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      tmr_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      log2_q <= LOG_W'(DEFAULT_LOG2);
    end else begin
      done_q <= fire_o;
      if (change) begin
        code_q <= code_i;
        tmr_q  <= TMR_W'(SETTLE_CYCLES);
        busy_q <= 1'b1;
      end else if (fire_o) begin
        busy_q <= 1'b0;
        tmr_q  <= '0;
        log2_q <= code_log2(code_q, LOG_W'(DEFAULT_LOG2));
      end else if (busy_q) begin
        tmr_q <= tmr_q - TMR_W'(1);
      end
    end
  end

  assign log2_o = log2_q;
  assign busy_o = busy_q;
  assign done_o = done_q;
endmodule

// File: rtl/rate_div_cnt.sv
module rate_div_cnt
  import rate_div_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LOG_W-1:0] log2_i,
  input  logic             clr_i,
  output logic             tick_o
);
  localparam int CNT_W = MAX_LOG2;

  logic [CNT_W-1:0] cnt_q, lim;
  logic             run_q;

  assign lim = CNT_W'((1 << log2_i) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      run_q <= 1'b1;
      if (clr_i || cnt_q >= lim) cnt_q <= '0;
      else                       cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign tick_o = run_q && (cnt_q == lim);
endmodule

// File: rtl/rate_div.sv
module rate_div
  import rate_div_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int DEFAULT_LOG2  = 1,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       async_mode_i,
  input  logic [2:0] rate_i,
  output logic       tick_o,
  output logic       done_o
);
  rate_code_t       rate_s;
  logic [LOG_W-1:0] act_log2;
  logic             fire, busy;

  rate_div_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .async_mode_i, .d_i(rate_i), .q_o(rate_s)
  );

  rate_div_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES), .DEFAULT_LOG2(DEFAULT_LOG2)) u_ctrl (
    .clk_i, .rst_ni, .code_i(rate_s), .log2_o(act_log2), .fire_o(fire),
    .busy_o(busy), .done_o(done_o)
  );

  rate_div_cnt u_cnt (
    .clk_i, .rst_ni, .log2_i(act_log2), .clr_i(fire), .tick_o(tick_o)
  );
endmodule

// File: rtl/rate_div_chk.sv
module rate_div_chk
  import rate_div_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_o,
  input logic             done_o,
  input logic             busy,
  input logic [2:0]       rate_s,
  input logic [LOG_W-1:0] act_log2,
  input logic             fire
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R3

  AST_DONE_AFTER_TIMER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy)); // R4

  AST_RESERVED_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_s > 3'd4 && !busy) |=> !busy); // R7

  AST_TICK_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && act_log2 != '0 && !fire) |=> !tick_o); // R2

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_STOP_IN_RESET: assert (!tick_o && !done_o); // R6
    end
  end
endmodule

bind rate_div rate_div_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick_o), .done_o(done_o),
  .busy(busy), .rate_s(rate_s), .act_log2(act_log2), .fire(fire)
);

// File: tb/rate_div_tb.sv
module rate_div_tb;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 4;
  localparam int WIN        = 40;
  localparam int NVEC       = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       async_mode = 1'b0;
  logic [2:0] rate = 3'd0;
  logic       tick, done;

  int checks = 0;
  int errors = 0;
  bit tk_h [WIN];
  bit dn_h [WIN];

  always #(CLK_PERIOD/2) clk = ~clk;

  rate_div #(.SETTLE_CYCLES(SETTLE), .DEFAULT_LOG2(1)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .async_mode_i(async_mode), .rate_i(rate),
    .tick_o(tick), .done_o(done)
  );

  // {async, code, changes, N}
  typedef struct packed { bit as; logic [2:0] code; bit chg; int n; } vec_t;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 3'd3, 1'b1, 4},  // R2
    '{1'b0, 3'd1, 1'b1, 1},  // R2
    '{1'b0, 3'd4, 1'b1, 8},  // R2
    '{1'b0, 3'd0, 1'b1, 2},  // R1
    '{1'b0, 3'd6, 1'b0, 2},  // R7
    '{1'b0, 3'd0, 1'b0, 2},  // R3 same code
    '{1'b1, 3'd2, 1'b1, 2},  // R5
    '{1'b1, 3'd4, 1'b1, 8}   // R5
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe();
    for (int k = 0; k < WIN; k++) begin
      @(posedge clk); @(negedge clk);
      tk_h[k] = tick;
      dn_h[k] = done;
    end
  endtask

  function automatic int done_count();
    int c = 0;
    for (int k = 0; k < WIN; k++) c += int'(dn_h[k]);
    return c;
  endfunction

  function automatic int done_index();
    for (int k = 0; k < WIN; k++) if (dn_h[k]) return k;
    return -1;
  endfunction

  function automatic int first_tick_from(input int s);
    for (int k = s; k < WIN; k++) if (tk_h[k]) return k;
    return -1;
  endfunction

  function automatic int tail_ticks();
    int c = 0;
    for (int k = WIN - 16; k < WIN; k++) c += int'(tk_h[k]);
    return c;
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int di;
    // reset state
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!tick && !done, "R6 reset outputs", int'(tick) + int'(done), 0);
    end
    rst_n = 1'b1;
    observe();
    chk(done_count() == 0, "R6 no done after reset", done_count(), 0);
    chk(tail_ticks() == 8, "R1 default ratio", tail_ticks(), 8);

    // table walk
    for (int v = 0; v < NVEC; v++) begin
      async_mode = VECS[v].as;
      rate = VECS[v].code;
      observe();
      if (VECS[v].chg) begin
        di = done_index();
        chk(done_count() == 1, "R3 one done per change", done_count(), 1);
        chk(di == (VECS[v].as ? SETTLE + 2 : SETTLE), VECS[v].as ? "R5 async latency" : "R4 sync latency",
            di, VECS[v].as ? SETTLE + 2 : SETTLE);
        chk(first_tick_from(di) == di + VECS[v].n - 1, "R9 first period complete",
            first_tick_from(di), di + VECS[v].n - 1);
      end else begin
        chk(done_count() == 0, "R7 no done for reserved or same code", done_count(), 0);
      end
      chk(tail_ticks() == 16 / VECS[v].n, "R2 tick rate", tail_ticks(), 16 / VECS[v].n);
    end

    // restart during settle
    async_mode = 1'b0;
    rate = 3'd3;
    for (int k = 0; k < 2; k++) begin
      @(posedge clk); @(negedge clk);
      chk(!done, "R8 no early done", int'(done), 0);
    end
    rate = 3'd1;
    observe();
    chk(done_count() == 1, "R8 single done", done_count(), 1);
    chk(done_index() == SETTLE, "R8 restarted latency", done_index(), SETTLE);
    chk(tail_ticks() == 16, "R8 latest code used", tail_ticks(), 16);

    // reserved while running
    rate = 3'd7;
    observe();
    chk(done_count() == 0, "R7 reserved no done", done_count(), 0);
    chk(tail_ticks() == 16, "R7 ratio kept", tail_ticks(), 16);

    // reset stops output mid-run
    @(negedge clk);
    rst_n = 1'b0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(!tick && !done, "R6 output stopped", int'(tick), 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule